// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one global register with the outcomes of the most recent branches and a table of small saturating up/down counters. A counter is chosen by combining low bits of the branch address with that global history. As a result, the same branch can use different counters depending on what the preceding branches did.

A fetch stage presents a PC on the lookup port and gets a taken or not-taken verdict in the same cycle, with no register on that path. When the branch resolves, the back end presents the same PC and the real outcome on the update port. The update moves the selected counter one step towards that outcome and then pushes the outcome into the history.

A build-time mode picks how the table index is formed. One mode places the history above the address bits. The other XORs the address bits with the history, which gives a smaller table.

Top module: `gbp_dir_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 2^(n-1)-1 (weakly not-taken), so every lookup returns not-taken.
- R2: A lookup returns taken exactly when the selected counter is at least 2^(n-1). This is combinational from `lk_pc` and the current state.
- R3: An update with outcome taken adds one to the selected counter, and the counter saturates at 2^n-1.
- R4: An update with outcome not-taken subtracts one from the selected counter, and the counter saturates at 0.
- R5: With n = 2, a counter at its strongly-taken value keeps predicting taken after one not-taken update. It predicts not-taken only after a second not-taken update to the same entry.
- R6: Each update shifts the outcome into history bit 0 (1 = taken), and the oldest bit drops out. In concatenated mode the table index is {history, pc[m+1:2]}.
- R7: In hashed mode the table index is pc[m+1:2] XOR history, both zero-extended to the wider of the two.
- R8: A lookup in the same cycle as an update sees the state from before that update. The update becomes visible to lookups from the next cycle on. Only one counter changes per update.
- R9: While `up_valid` is low, no counter and no history bit changes. PC bits outside pc[m+1:2] have no effect on any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Prediction: 1 = taken |
| up_valid | input | 1 | Commit a resolved branch this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome: 1 = taken |

## Verification
The bench sweeps every address index after each update, both in concatenated and in hashed mode. It compares the results with a counter model that it indexes with its own arithmetic. This catches an index built from the wrong PC bits or with the history in the wrong place, which would make predictions follow the wrong counter.

Long runs of one outcome push counters against both rails. A design that wraps at a rail would flip its prediction after one extra step. A directed sequence steers the history back to the same entry twice, to show that one misprediction does not flip a strong counter.

Lookups made in the same cycle as an update catch write-through forwarding, which would give the new value one cycle early. Idle cycles with changing update inputs, together with random upper PC bits, catch writes that leak when `up_valid` is low and index bits taken from the wrong field.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  typedef enum logic [0:0] {
    IDX_CONCAT = 1'b0,
    IDX_HASH   = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   shifted;

  // newest outcome enters at bit 0, oldest falls off the top
  assign shifted = {hist_q, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= shifted[HIST_W-1:0];
  end

  assign hist = hist_q;
endmodule

// File: rtl/gbp_index.sv
module gbp_index
  import gbp_pkg::*;
#(
  parameter idx_mode_e MODE      = IDX_CONCAT,
  parameter int        HIST_W    = 2,
  parameter int        ADDR_BITS = 4,
  parameter int        PC_W      = 32,
  parameter int        IDX_W     = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_BITS-1:0] addr_field;

  // word-aligned address: the two lowest bits never select
  assign addr_field = pc[ADDR_BITS+1:2];

  generate
    if (MODE == IDX_HASH) begin : g_hash
      logic [IDX_W-1:0] addr_ext;
      logic [IDX_W-1:0] hist_ext;
      assign addr_ext = IDX_W'(addr_field);
      assign hist_ext = IDX_W'(hist);
      assign idx      = addr_ext ^ hist_ext;
    end else begin : g_concat
      assign idx = {hist, addr_field};
    end
  endgenerate
endmodule

// File: rtl/gbp_ctr_table.sv
module gbp_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_taken,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_taken,
  output logic [CTR_W-1:0]   wr_old,
  output logic [CTR_W-1:0]   wr_new,
  output logic [ENTRIES-1:0] wr_sel
);
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_HALF = CTR_W'(1) << (CTR_W - 1);
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_HALF - CTR_W'(1);

  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] v,
                                                 input logic up);
    if (up) return (v == CTR_MAX) ? v : v + CTR_W'(1);
    else    return (v == '0)      ? v : v - CTR_W'(1);
  endfunction

  function automatic logic ctr_says_taken(input logic [CTR_W-1:0] v);
    return v >= CTR_HALF;
  endfunction

  logic [CTR_W-1:0] ctr_q [ENTRIES];

  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  genvar i;
  generate
    for (i = 0; i < ENTRIES; i++) begin : g_ent
      assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ctr_q[i] <= CTR_INIT;
        else if (wr_sel[i]) ctr_q[i] <= wr_new;
      end
    end
  endgenerate

  assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);
endmodule

// File: rtl/gbp_dir_predictor.sv
module gbp_dir_predictor
  import gbp_pkg::*;
#(
  parameter idx_mode_e MODE      = IDX_CONCAT,
  parameter int        HIST_W    = 2,
  parameter int        ADDR_BITS = 4,
  parameter int        CTR_W     = 2,
  parameter int        PC_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int WIDE_W  = (HIST_W > ADDR_BITS) ? HIST_W : ADDR_BITS;
  localparam int IDX_W   = (MODE == IDX_HASH) ? WIDE_W : (HIST_W + ADDR_BITS);
  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0]  hist;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   up_idx;
  logic [CTR_W-1:0]   upd_old;
  logic [CTR_W-1:0]   upd_new;
  logic [ENTRIES-1:0] wr_sel;

  gbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (up_valid),
    .bit_in   (up_taken),
    .hist     (hist)
  );

  gbp_index #(.MODE(MODE), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS),
              .PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc   (lk_pc),
    .hist (hist),
    .idx  (lk_idx)
  );

  gbp_index #(.MODE(MODE), .HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS),
              .PC_W(PC_W), .IDX_W(IDX_W)) u_up_idx (
    .pc   (up_pc),
    .hist (hist),
    .idx  (up_idx)
  );

  gbp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_taken (lk_taken),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken),
    .wr_old   (upd_old),
    .wr_new   (upd_new),
    .wr_sel   (wr_sel)
  );
endmodule

// File: rtl/gbp_checker.sv
module gbp_checker #(
  parameter int HIST_W  = 2,
  parameter int CTR_W   = 2,
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_valid,
  input logic               up_taken,
  input logic [HIST_W-1:0]  hist,
  input logic [CTR_W-1:0]   upd_old,
  input logic [CTR_W-1:0]   upd_new,
  input logic [ENTRIES-1:0] wr_sel
);
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist == HIST_W'({$past(hist), $past(up_taken)}));

  assert_hist_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));

  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel) && (up_valid == (wr_sel != '0)));

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |->
      ((upd_old == CMAX) ? (upd_new == CMAX) : (upd_new > upd_old)));

  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |->
      ((upd_old == '0) ? (upd_new == '0) : (upd_new < upd_old)));
endmodule

bind gbp_dir_predictor gbp_checker #(
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W),
  .ENTRIES(ENTRIES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_taken (up_taken),
  .hist     (hist),
  .upd_old  (upd_old),
  .upd_new  (upd_new),
  .wr_sel   (wr_sel)
);

// File: tb/sim_gbp_dir_predictor.sv
`timescale 1ns/1ps
module sim_gbp_dir_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        p_cat, p_hsh;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_cat [64];
  int m_hsh [16];
  int m_hist = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2 clk = ~clk;

  gbp_dir_predictor #(.MODE(gbp_pkg::IDX_CONCAT)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p_cat),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  gbp_dir_predictor #(.MODE(gbp_pkg::IDX_HASH)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(p_hsh),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic make_pc(input int a, output logic [31:0] pc);
    lfsr = next_rand(lfsr);
    pc = (lfsr & 32'hFFFF_FFC3) | (32'(a) << 2);
  endtask

  function automatic bit pred_cat(input int a);
    return m_cat[m_hist * 16 + a] >= 2;
  endfunction

  function automatic bit pred_hsh(input int a);
    return m_hsh[(a ^ m_hist) & 15] >= 2;
  endfunction

  function automatic int step(input int v, input bit t);
    if (t) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req,
                     input string inst, input int a);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%0d hist=%0d actual=%0b expected=%0b",
               req, inst, a, m_hist, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) begin
      logic [31:0] pc;
      @(negedge clk);
      make_pc(a, pc);
      lk_pc = pc;
      #1;
      chk(p_cat, pred_cat(a), req, "concat", a);
      chk(p_hsh, pred_hsh(a), req, "hashed", a);
    end
  endtask

  task automatic look(input int a, input bit exp_cat, input string req);
    logic [31:0] pc;
    @(negedge clk);
    make_pc(a, pc);
    lk_pc = pc;
    #1;
    chk(p_cat, exp_cat, req, "concat", a);
    chk(p_cat, pred_cat(a), req, "concat-model", a);
    chk(p_hsh, pred_hsh(a), req, "hashed", a);
  endtask

  task automatic upd(input int a, input bit t);
    logic [31:0] pc;
    @(negedge clk);
    make_pc(a, pc);
    up_pc = pc;
    make_pc(a, pc);
    lk_pc = pc;
    up_taken = t;
    up_valid = 1'b1;
    #1;
    // R8: same-cycle lookup still sees the pre-update counter
    chk(p_cat, pred_cat(a), "R8", "concat", a);
    chk(p_hsh, pred_hsh(a), "R8", "hashed", a);
    @(posedge clk);
    m_cat[m_hist * 16 + a] = step(m_cat[m_hist * 16 + a], t);
    m_hsh[(a ^ m_hist) & 15] = step(m_hsh[(a ^ m_hist) & 15], t);
    m_hist = ((m_hist << 1) | int'(t)) & 3;
    #1;
    up_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_cat[i] = 1;
    for (int i = 0; i < 16; i++) m_hsh[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything weakly not-taken, history zero
    sweep("R1");

    // R5: drive entry (hist=3, addr=5) to strong taken, then two misses
    for (int i = 0; i < 4; i++) upd(5, 1'b1);
    look(5, 1'b1, "R5");
    upd(5, 1'b0);
    upd(9, 1'b1);
    upd(9, 1'b1);
    look(5, 1'b1, "R5");
    upd(5, 1'b0);
    upd(9, 1'b1);
    upd(9, 1'b1);
    look(5, 1'b0, "R5");

    // R3: long taken run saturates the top rail
    for (int i = 0; i < 6; i++) upd(3, 1'b1);
    sweep("R3");
    // R4: long not-taken run saturates the bottom rail
    for (int i = 0; i < 8; i++) upd(3, 1'b0);
    sweep("R4");
    upd(3, 1'b1);
    sweep("R4");

    // R2 R6 R7: mixed outcomes across many addresses
    for (int i = 0; i < 240; i++) begin
      lfsr = next_rand(lfsr);
      upd(int'(lfsr[7:4]), lfsr[2] ^ lfsr[9]);
      if (i % 12 == 11) sweep("R2 R6 R7");
    end

    // R9: update inputs wiggle with up_valid low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lfsr = next_rand(lfsr);
      up_pc = lfsr;
      up_taken = lfsr[3];
    end
    sweep("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule